// File: doc/BRIEF.md
# JTAG Instruction and Data Register Path

This block holds the registers that a JTAG test access port scans. It contains an instruction shift stage, the held instruction that the rest of the chip decodes, a one-bit bypass register and an optional 32-bit identification register. A separate TAP state machine drives it with capture, shift and update strobes and a flag that says whether the current scan is an instruction scan or a data scan. The block shifts the selected register one bit per clock from the serial input toward the serial output.

The held instruction picks which data register is scanned. The all-ones code and every code with no assignment select bypass. One parameterised code selects the identification register. The instruction shift stage is never loaded from the held instruction. Its capture value is a fixed pattern that ends in binary 01, so the active instruction cannot be read back. The held instruction changes only when an instruction-scan update strobe arrives. This means a scan may be paused and resumed at any point without disturbing the logic that consumes the instruction.

Top module: `jtag_regpath`

## Requirements
- R1: While `rst_n` is low, `instr` holds IDCODE_OP (default 6'h02) and `is_idcode` is 1. When HAS_IDCODE is 0, it holds all ones instead.
- R2: A capture strobe with `sel_ir`=1 loads the instruction shift stage with IR_CAP_FILL, with bit 1 forced to 0 and bit 0 forced to 1. The first two bits shifted out afterwards are therefore 1 and then 0.
- R3: `instr` changes only on a clock edge where `update` and `sel_ir` are both 1. It then takes the contents of the instruction shift stage.
- R4: During an instruction scan the stage shifts one bit per clock, from `tdi` toward `tdo`. After IR_W shifts, `tdo` repeats `tdi` delayed by IR_W clocks. Clocks without a shift strobe leave the stage unchanged.
- R5: When `instr` is all ones, `is_bypass` is 1. A data-scan capture clears the bypass bit to 0, and data-scan shifting delays `tdi` by exactly one clock.
- R6: When `instr` equals IDCODE_OP, a data-scan capture loads ID_VALUE (default 32'h4A3C1E5B, bit 0 set). Shifting then returns ID_VALUE least significant bit first, followed by `tdi` delayed by 32 clocks.
- R7: Any `instr` value other than IDCODE_OP behaves as bypass: `is_bypass`=1, `is_idcode`=0, and the data path is one bit long.
- R8: `tdo_en` equals `shift`. `tdo` is 0 whenever `shift` is 0.
- R9: Registers that are not selected neither shift nor capture. A partly shifted identification register keeps its remaining bits across an instruction scan that re-selects it.
- R10: Data-scan update strobes and instruction-scan capture strobes leave `instr` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock; all registers change on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; presets the held instruction |
| sel_ir | input | 1 | 1 = instruction scan, 0 = data scan |
| capture | input | 1 | Capture strobe from the TAP state machine |
| shift | input | 1 | Shift strobe from the TAP state machine |
| update | input | 1 | Update strobe from the TAP state machine |
| tdi | input | 1 | Serial test data in |
| tdo | output | 1 | Serial test data out; 0 when not shifting |
| tdo_en | output | 1 | Output enable for the serial pin |
| instr | output | IR_W | Held (committed) instruction |
| is_bypass | output | 1 | Held instruction selects the bypass register |
| is_idcode | output | 1 | Held instruction selects the identification register |

## Verification
A corrupted instruction shift stage shows up on `tdo` within IR_W shift clocks. It also appears on `instr` at the next update, and from then on it alters the length of the data path. A held instruction that changes without an update is visible on the very next clock edge at `instr` and the decode flags. A data register that shifts while unselected shows up only later, when a resumed data scan returns the wrong remaining bits. The bench therefore pauses an identification scan, runs an instruction scan, and resumes it. The reference model compares every serial bit and every decode output on each clock.

// File: rtl/jtag_rp_pkg.sv
package jtag_rp_pkg;
   typedef enum logic [1:0] {
      PATH_IR  = 2'd0,
      PATH_BYP = 2'd1,
      PATH_ID  = 2'd2
   } path_e;
endpackage

// File: rtl/jtag_ir_stage.sv
// Instruction shift stage plus committed (held) instruction.
module jtag_ir_stage #(
   parameter int                 IR_W   = 6,
   parameter logic [IR_W-1:0]    CAP    = 6'b000001,
   parameter logic [IR_W-1:0]    RST_OP = 6'b000010
) (
   input  logic            tck,
   input  logic            rst_n,
   input  logic            cap_en,
   input  logic            shift_en,
   input  logic            upd_en,
   input  logic            tdi,
   output logic            so,
   output logic [IR_W-1:0] held
);
   logic [IR_W-1:0] sr;

   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n) begin
         sr <= CAP;
      end else if (cap_en) begin
         sr <= CAP;
      end else if (shift_en) begin
         sr <= {tdi, sr[IR_W-1:1]};
      end
   end

   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n) begin
         held <= RST_OP;
      end else if (upd_en && !cap_en && !shift_en) begin
         held <= sr;
      end
   end

   assign so = sr[0];
endmodule

// File: rtl/jtag_dr_cell.sv
// Generic capture/shift data register; width 1 gives the bypass bit.
module jtag_dr_cell #(
   parameter int            W   = 32,
   parameter logic [W-1:0]  CAP = '0
) (
   input  logic tck,
   input  logic rst_n,
   input  logic cap_en,
   input  logic shift_en,
   input  logic tdi,
   output logic so
);
   logic [W-1:0] q;

   generate
      if (W == 1) begin : g_single
         always_ff @(posedge tck or negedge rst_n) begin
            if (!rst_n)        q <= CAP;
            else if (cap_en)   q <= CAP;
            else if (shift_en) q <= tdi;
         end
      end else begin : g_multi
         always_ff @(posedge tck or negedge rst_n) begin
            if (!rst_n)        q <= CAP;
            else if (cap_en)   q <= CAP;
            else if (shift_en) q <= {tdi, q[W-1:1]};
         end
      end
   endgenerate

   assign so = q[0];
endmodule

// File: rtl/jtag_regpath.sv
module jtag_regpath
   import jtag_rp_pkg::*;
#(
   parameter int                 IR_W        = 6,
   parameter logic [IR_W-1:0]    IDCODE_OP   = 6'h02,
   parameter logic [IR_W-1:0]    IR_CAP_FILL = '0,
   parameter bit                 HAS_IDCODE  = 1'b1,
   parameter int                 ID_W        = 32,
   parameter logic [ID_W-1:0]    ID_VALUE    = 32'h4A3C_1E5B
) (
   input  logic            tck,
   input  logic            rst_n,
   input  logic            sel_ir,
   input  logic            capture,
   input  logic            shift,
   input  logic            update,
   input  logic            tdi,
   output logic            tdo,
   output logic            tdo_en,
   output logic [IR_W-1:0] instr,
   output logic            is_bypass,
   output logic            is_idcode
);
   localparam logic [IR_W-1:0] IR_CAP   = {IR_CAP_FILL[IR_W-1:2], 2'b01};
   localparam logic [IR_W-1:0] BYP_OP   = '1;
   localparam logic [IR_W-1:0] RESET_OP = HAS_IDCODE ? IDCODE_OP : BYP_OP;

   // elaboration-time parameter checks
   if (IR_W < 2) begin : g_bad_irw
      initial $fatal(1, "IR_W must be at least 2");
   end
   if (HAS_IDCODE && (IDCODE_OP == BYP_OP)) begin : g_bad_op
      initial $fatal(1, "IDCODE_OP must differ from the all-ones code");
   end
   if (HAS_IDCODE && !ID_VALUE[0]) begin : g_bad_id
      initial $fatal(1, "ID_VALUE bit 0 must be 1");
   end

   path_e path;
   logic  ir_so, byp_so, id_so;
   logic  id_hit;

   assign id_hit = HAS_IDCODE && (instr == IDCODE_OP);
   assign path   = sel_ir ? PATH_IR : (id_hit ? PATH_ID : PATH_BYP);

   jtag_ir_stage #(
      .IR_W   (IR_W),
      .CAP    (IR_CAP),
      .RST_OP (RESET_OP)
   ) i_ir (
      .tck      (tck),
      .rst_n    (rst_n),
      .cap_en   (capture && sel_ir),
      .shift_en (shift && sel_ir),
      .upd_en   (update && sel_ir),
      .tdi      (tdi),
      .so       (ir_so),
      .held     (instr)
   );

   jtag_dr_cell #(
      .W   (1),
      .CAP (1'b0)
   ) i_byp (
      .tck      (tck),
      .rst_n    (rst_n),
      .cap_en   (capture && path == PATH_BYP),
      .shift_en (shift && path == PATH_BYP),
      .tdi      (tdi),
      .so       (byp_so)
   );

   generate
      if (HAS_IDCODE) begin : g_id
         jtag_dr_cell #(
            .W   (ID_W),
            .CAP (ID_VALUE)
         ) i_id (
            .tck      (tck),
            .rst_n    (rst_n),
            .cap_en   (capture && path == PATH_ID),
            .shift_en (shift && path == PATH_ID),
            .tdi      (tdi),
            .so       (id_so)
         );
      end else begin : g_no_id
         assign id_so = 1'b0;
      end
   endgenerate

   logic mux_out;
   always_comb begin
      unique case (path)
         PATH_IR: mux_out = ir_so;
         PATH_ID: mux_out = id_so;
         default: mux_out = byp_so;
      endcase
   end

   assign tdo       = shift && mux_out;
   assign tdo_en    = shift;
   assign is_idcode = id_hit;
   assign is_bypass = !id_hit;
endmodule

// File: rtl/jtag_regpath_chk.sv
module jtag_regpath_chk #(
   parameter int              IR_W       = 6,
   parameter logic [IR_W-1:0] IDCODE_OP  = 6'h02,
   parameter bit              HAS_IDCODE = 1'b1
) (
   input logic            tck,
   input logic            rst_n,
   input logic            sel_ir,
   input logic            capture,
   input logic            shift,
   input logic            update,
   input logic            tdi,
   input logic            tdo,
   input logic            tdo_en,
   input logic [IR_W-1:0] instr,
   input logic            is_bypass,
   input logic            is_idcode
);
   a_r1_reset_preset: assert property (@(posedge tck)
      $rose(rst_n) |-> (HAS_IDCODE ? (instr == IDCODE_OP) : (&instr)));

   a_r2_ir_capture_lsb: assert property (@(posedge tck) disable iff (!rst_n)
      (sel_ir && shift && $past(sel_ir && capture && rst_n)) |-> tdo);

   a_r3_hold_only_on_update: assert property (@(posedge tck) disable iff (!rst_n)
      !(update && sel_ir) |=> $stable(instr));

   a_r5_bypass_one_bit: assert property (@(posedge tck) disable iff (!rst_n)
      (shift && !sel_ir && is_bypass &&
       $past(shift && !sel_ir && !capture && rst_n)) |-> (tdo == $past(tdi)));

   a_r7_unassigned_bypass: assert property (@(posedge tck) disable iff (!rst_n)
      (!HAS_IDCODE || instr != IDCODE_OP) |-> (is_bypass && !is_idcode));

   a_r8_quiet_when_idle: assert property (@(posedge tck) disable iff (!rst_n)
      !shift |-> (!tdo_en && !tdo));
endmodule

bind jtag_regpath jtag_regpath_chk #(
   .IR_W       (IR_W),
   .IDCODE_OP  (IDCODE_OP),
   .HAS_IDCODE (HAS_IDCODE)
) i_chk (.*);

// File: tb/test_jtag_regpath.sv
module test_jtag_regpath;
   localparam int CLK_PERIOD = 10;
   localparam int IR_W       = 6;
   localparam logic [IR_W-1:0] IDC = 6'h02;
   localparam logic [31:0] IDV = 32'h4A3C_1E5B;

   logic tck = 0, rst_n = 0, sel_ir = 0, capture = 0, shift = 0, update = 0, tdi = 0;
   logic tdo, tdo_en, is_bypass, is_idcode;
   logic [IR_W-1:0] instr;

   int checks = 0, fails = 0;

   // behavioural reference state
   bit ir_q[$];
   bit id_q[$];
   bit byp_m;
   logic [IR_W-1:0] hold_m;

   always #(CLK_PERIOD/2) tck = ~tck;

   jtag_regpath i_jtag_regpath (
      .tck(tck), .rst_n(rst_n), .sel_ir(sel_ir), .capture(capture), .shift(shift),
      .update(update), .tdi(tdi), .tdo(tdo), .tdo_en(tdo_en), .instr(instr),
      .is_bypass(is_bypass), .is_idcode(is_idcode)
   );

   function automatic void load_ir_cap();
      ir_q.delete();
      ir_q.push_back(1'b1);
      ir_q.push_back(1'b0);
      for (int i = 2; i < IR_W; i++) ir_q.push_back(1'b0);
   endfunction

   function automatic void load_id_cap();
      id_q.delete();
      for (int i = 0; i < 32; i++) id_q.push_back(IDV[i]);
   endfunction

   function automatic logic [IR_W-1:0] ir_value();
      logic [IR_W-1:0] v;
      for (int i = 0; i < IR_W; i++) v[i] = ir_q[i];
      return v;
   endfunction

   always @(posedge tck or negedge rst_n) begin
      if (!rst_n) begin
         load_ir_cap();
         load_id_cap();
         byp_m  = 1'b0;
         hold_m = IDC;
      end else if (sel_ir) begin
         if (capture) load_ir_cap();
         else if (shift) begin
            void'(ir_q.pop_front());
            ir_q.push_back(tdi);
         end else if (update) hold_m = ir_value();
      end else if (hold_m == IDC) begin
         if (capture) load_id_cap();
         else if (shift) begin
            void'(id_q.pop_front());
            id_q.push_back(tdi);
         end
      end else begin
         if (capture) byp_m = 1'b0;
         else if (shift) byp_m = tdi;
      end
   end

   task automatic chk(string req, string what, int act, int exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic compare(string req);
      logic exp_tdo;
      if (!shift) exp_tdo = 1'b0;
      else if (sel_ir) exp_tdo = ir_q[0];
      else if (hold_m == IDC) exp_tdo = id_q[0];
      else exp_tdo = byp_m;
      chk(req, "tdo", int'(tdo), int'(exp_tdo));
      chk(req, "tdo_en", int'(tdo_en), int'(shift));
      chk(req, "instr", int'(instr), int'(hold_m));
      chk(req, "is_idcode", int'(is_idcode), int'(hold_m == IDC));
      chk(req, "is_bypass", int'(is_bypass), int'(hold_m != IDC));
   endtask

   // drive at falling edge, check mid-phase, then pass one rising edge
   task automatic step(logic s, logic c, logic sh, logic u, logic d, string req);
      sel_ir = s; capture = c; shift = sh; update = u; tdi = d;
      #1;
      compare(req);
      @(posedge tck);
      @(negedge tck);
   endtask

   task automatic load_ir(logic [IR_W-1:0] code, string req);
      step(1, 1, 0, 0, 0, req);
      for (int i = 0; i < IR_W; i++) step(1, 0, 1, 0, code[i], req);
      step(1, 0, 0, 1, 0, req);
      step(1, 0, 0, 0, 0, req);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      @(negedge tck); @(negedge tck);
      #1; compare("R1");
      @(negedge tck);
      rst_n = 1;
      step(0, 0, 0, 0, 0, "R1");

      // R6: identification scan, 32 ID bits then tdi delayed 32
      step(0, 1, 0, 0, 0, "R6");
      for (int i = 0; i < 40; i++) step(0, 0, 1, 0, 1'($urandom()), "R6");
      step(0, 0, 0, 1, 0, "R10");  // data update: instr unchanged

      // R2 / R4: instruction scan, captured 01 then delayed tdi
      step(1, 1, 0, 0, 0, "R2");
      for (int i = 0; i < IR_W + 4; i++) step(1, 0, 1, 0, 1'b1, "R4");
      step(1, 0, 0, 0, 1, "R3");
      step(1, 1, 0, 0, 0, "R10");  // instruction capture: instr unchanged
      for (int i = 0; i < IR_W; i++) step(1, 0, 1, 0, 1'b1, "R4");
      step(1, 0, 0, 1, 0, "R3");
      chk("R5", "is_bypass after all-ones", int'(is_bypass), 1);

      // R5: bypass path
      step(0, 1, 0, 0, 1, "R5");
      for (int i = 0; i < 12; i++) step(0, 0, 1, 0, 1'($urandom()), "R5");

      // R8: idle with toggling tdi
      for (int i = 0; i < 4; i++) step(i[0], 0, 0, 0, i[1], "R8");

      // R7: unassigned code behaves as bypass
      load_ir(6'h05, "R7");
      chk("R7", "instr loaded", int'(instr), 5);
      step(0, 1, 0, 0, 0, "R7");
      for (int i = 0; i < 8; i++) step(0, 0, 1, 0, 1'($urandom()), "R7");

      // R4: paused instruction scan
      step(1, 1, 0, 0, 0, "R4");
      for (int i = 0; i < 3; i++) step(1, 0, 1, 0, IDC[i], "R4");
      step(1, 0, 0, 0, 1, "R4");
      step(1, 0, 0, 0, 0, "R4");
      for (int i = 3; i < IR_W; i++) step(1, 0, 1, 0, IDC[i], "R4");
      step(1, 0, 0, 1, 0, "R3");
      chk("R6", "is_idcode selected", int'(is_idcode), 1);

      // R9: partial ID scan survives an instruction scan
      step(0, 1, 0, 0, 0, "R9");
      for (int i = 0; i < 5; i++) step(0, 0, 1, 0, 1'($urandom()), "R9");
      load_ir(IDC, "R9");
      for (int i = 0; i < 30; i++) step(0, 0, 1, 0, 1'($urandom()), "R9");

      // R1: reset after a non-default instruction
      load_ir(6'h3F, "R3");
      rst_n = 0;
      #1; compare("R1");
      @(negedge tck);
      compare("R1");
      rst_n = 1;
      step(0, 0, 0, 0, 0, "R1");

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule